// File: doc/BRIEF.md
# Triangle Dither Offset Generator

This block produces an unsigned trim code that traces a triangle wave, for use as a downward frequency offset on an oscillator. Applying the code produces a spread-spectrum clock. It runs on the master clock. The triangle period is locked to 4096 master cycles, so the dither rate is the master frequency divided by 4096. The code only ever lowers frequency. Its range runs from zero up to a peak that stands for either a 4% or a 2% deviation, and a single depth bit chooses between them. The block changes only the trim value. The duty cycle of the modulated clock is set by the oscillator and is not touched here.

A small state machine holds three states. `ST_IDLE` means no dither. `ST_RISE` means the code is climbing. `ST_FALL` means the code is descending. The transitions are:

- IDLE→RISE, named *launch*, taken when spread is enabled.
- RISE→FALL, named *crest*, taken when the count reaches its top.
- FALL→RISE, named *rebound*, taken at the bottom while spread stays enabled.
- FALL→IDLE, named *park*, taken at the bottom once spread has been removed.

Dropping the enable never cuts the triangle short. The wave always finishes its descent first. The depth choice is taken up only at the bottom of the wave, so the code never jumps in the middle of a ramp. A one-cycle turn pulse marks every crest and every rebound.

Top module: `tri_dither_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `dith_offset` is 0 and `turn_pulse` is 0.
- R2: In IDLE with `spread_en` low, `dith_offset` stays 0. The edge that samples `spread_en` high takes the launch transition. The code is then 0 for one more cycle and increases from the following cycle on.
- R3: Once launched, a raw count steps up by 1 each cycle through 0..2047, 2048 cycles in all. It then steps down through 2047..0, another 2048 cycles. A full period is 4096 cycles, and consecutive turn pulses are 2048 cycles apart.
- R4: With the captured depth bit at 0 (4% peak), `dith_offset` equals raw count × 2, so the peak code is 4094 and the code is always even.
- R5: With the captured depth bit at 1 (2% peak), `dith_offset` equals the raw count, so the peak code is 2047.
- R6: `depth_half` is sampled only on edges where the wave sits at its bottom (IDLE, or the last cycle of the descent). A change made at any other time has no effect on `dith_offset` until the next bottom.
- R7: When `spread_en` is low at the last cycle of a descent, the park transition is taken. The code then stays 0 until a new launch. A drop of `spread_en` at any earlier point leaves the triangle running.
- R8: `turn_pulse` is high for exactly one cycle in two places: the first descending cycle (crest), and the first cycle after a rebound. It stays low on launch and on park.
- R9: `dith_offset` never exceeds the peak code of the depth that is in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Enables the triangle dither |
| depth_half | input | 1 | 1 selects the 2% peak, 0 selects the 4% peak |
| dith_offset | output | 12 | Downward frequency trim code |
| turn_pulse | output | 1 | One-cycle pulse at each triangle direction change |

## Verification
Every output is driven straight from registers with no further register stage. A change on `spread_en` or `depth_half` therefore shows up exactly one clock edge after the edge that samples it. The only exception is the launch, which keeps the code at 0 for one extra cycle. The bench drives its inputs on falling edges and advances its reference model on each rising edge from the same inputs. It compares both outputs at the next falling edge, so every result is checked in the one cycle it is due. Turn-pulse spacing, the drain to zero after disable, and the peak codes of both depths are checked on top of the per-cycle comparison.

// File: rtl/tri_dither_pkg.sv
package tri_dither_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } phase_state_t;

endpackage

// File: rtl/tri_phase_fsm.sv
module tri_phase_fsm
    import tri_dither_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output logic [CNT_W-1:0] ramp_cnt,
    output logic             at_bottom,
    output logic             turn_strobe
);

    localparam logic [CNT_W-1:0] CNT_TOP  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    phase_state_t     state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             turn_q, turn_n;

    // next-state and next-count decision
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        turn_n  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_n = CNT_ZERO;
                if (run_en) begin
                    state_n = ST_RISE;              // launch
                end
            end
            ST_RISE: begin
                if (cnt_q == CNT_TOP) begin
                    state_n = ST_FALL;              // crest
                    turn_n  = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_FALL: begin
                if (cnt_q == CNT_ZERO) begin
                    if (run_en) begin
                        state_n = ST_RISE;          // rebound
                        turn_n  = 1'b1;
                    end else begin
                        state_n = ST_IDLE;          // park
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = CNT_ZERO;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn_q <= 1'b0;
        end else begin
            turn_q <= turn_n;
        end
    end

    assign ramp_cnt    = cnt_q;
    assign turn_strobe = turn_q;
    assign at_bottom   = (state_q == ST_IDLE) ||
                         (state_q == ST_FALL && cnt_q == CNT_ZERO);

    // R3: the count climbs by one per cycle below the top
    a_r3_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RISE && cnt_q != CNT_TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: the count descends by one per cycle above zero
    a_r3_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FALL && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a parked generator holds a zero count
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == CNT_ZERO));

    // R7: bottom of the descent with enable low parks the generator
    a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FALL && cnt_q == CNT_ZERO && !run_en) |=> (state_q == ST_IDLE));

    // R8: the turn pulse never lasts more than one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        turn_q |=> !turn_q);

    // R8: a pulse accompanies only a crest or a rebound
    a_r8_pulse_place: assert property (@(posedge clk) disable iff (!rst_n)
        turn_q |-> ((state_q == ST_FALL && cnt_q == CNT_TOP) ||
                    (state_q == ST_RISE && cnt_q == CNT_ZERO)));

endmodule

// File: rtl/tri_depth_scale.sv
module tri_depth_scale #(
    parameter int CNT_W  = 11,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              depth_in,
    input  logic [CNT_W-1:0]  raw_cnt,
    output logic [CODE_W-1:0] code_out
);

    localparam int PAD_W      = CODE_W - CNT_W;
    localparam int HALF_PEAK  = (1 << CNT_W) - 1;

    logic              half_q;
    logic [CODE_W-1:0] full_code;
    logic [CODE_W-1:0] half_code;

    // depth is only taken up at the bottom of the triangle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (capture) begin
            half_q <= depth_in;
        end
    end

    generate
        if (PAD_W == 1) begin : g_exact
            assign full_code = {raw_cnt, 1'b0};
        end else begin : g_padded
            assign full_code = {{(PAD_W-1){1'b0}}, raw_cnt, 1'b0};
        end
    endgenerate

    assign half_code = full_code >> 1;
    assign code_out  = half_q ? half_code : full_code;

    // R6: the captured depth holds between bottoms
    a_r6_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(half_q));

    // R4: the 4% code is always even
    a_r4_even_code: assert property (@(posedge clk) disable iff (!rst_n)
        !half_q |-> (code_out[0] == 1'b0));

    // R9: the 2% code never passes its peak
    a_r9_half_peak: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> (int'(code_out) <= HALF_PEAK));

endmodule

// File: rtl/tri_dither_gen.sv
module tri_dither_gen
    import tri_dither_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en,
    input  logic              depth_half,
    output logic [CODE_W-1:0] dith_offset,
    output logic              turn_pulse
);

    localparam int CNT_W = CODE_W - 1;

    logic [CNT_W-1:0] ramp_cnt;
    logic             at_bottom;

    tri_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (spread_en),
        .ramp_cnt    (ramp_cnt),
        .at_bottom   (at_bottom),
        .turn_strobe (turn_pulse)
    );

    tri_depth_scale #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (at_bottom),
        .depth_in (depth_half),
        .raw_cnt  (ramp_cnt),
        .code_out (dith_offset)
    );

    // R2: with spread off at the bottom, the code stays at zero next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bottom && !spread_en) |=> (dith_offset == '0));

    // R8: no pulse while parked at the bottom
    a_r8_quiet_park: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bottom && !spread_en) |=> !turn_pulse);

endmodule

// File: tb/tri_dither_gen_tb_top.sv
module tri_dither_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spread_en = 1'b0;
    logic        depth_half = 1'b0;
    logic [11:0] dith_offset;
    logic        turn_pulse;

    always #2.5 clk = ~clk;   // 200 MHz

    tri_dither_gen #(.CODE_W(12)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spread_en   (spread_en),
        .depth_half  (depth_half),
        .dith_offset (dith_offset),
        .turn_pulse  (turn_pulse)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference: phase index over one 4096-cycle period
    bit m_run   = 0;
    int m_phase = 0;
    bit m_depth = 0;
    bit m_turn  = 0;
    longint cyc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_phase = 0; m_depth = 0; m_turn = 0; cyc = 0;
        end else begin
            cyc = cyc + 1;
            if (!m_run || m_phase == 4095) m_depth = depth_half;
            if (!m_run) begin
                m_turn = 0;
                if (spread_en) begin m_run = 1; m_phase = 0; end
            end else if (m_phase == 4095) begin
                if (spread_en) begin m_phase = 0; m_turn = 1; end
                else begin m_run = 0; m_phase = 0; m_turn = 0; end
            end else begin
                m_phase = m_phase + 1;
                m_turn = (m_phase == 2048);
            end
        end
    end

    function automatic int exp_code();
        int raw;
        if (!m_run) return 0;
        raw = (m_phase < 2048) ? m_phase : 4095 - m_phase;
        return m_depth ? raw : raw * 2;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    int  max_full = 0;
    int  max_half = 0;
    longint last_turn = -1;

    // per-cycle comparison at the falling edge
    task automatic step_check();
        string tag;
        tag = !m_run ? "R2/R7" : (m_depth != depth_half) ? "R6" : (m_depth ? "R5" : "R4");
        chk(tag, int'(dith_offset), exp_code());
        chk("R8", int'(turn_pulse), int'(m_turn));
        if (m_run && !m_depth && int'(dith_offset) > max_full) max_full = int'(dith_offset);
        if (m_run &&  m_depth && int'(dith_offset) > max_half) max_half = int'(dith_offset);
        if (!m_run) last_turn = -1;
        if (turn_pulse) begin
            if (last_turn >= 0) chk("R3", int'(cyc - last_turn), 2048);
            last_turn = cyc;
        end
    endtask

    task automatic run(int n, bit en, bit dp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_check();
            spread_en  = en;
            depth_half = dp;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(dith_offset), 0);
        chk("R1", int'(turn_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(dith_offset), 0);
        chk("R1", int'(turn_pulse), 0);
        run(20, 0, 0);                 // R2 idle stays zero
        run(5000, 1, 0);               // R4 full depth
        run(8000, 1, 1);               // R6 change mid-ramp, R5 after bottom
        run(6000, 0, 1);               // R7 drain then park
        chk("R7", int'(dith_offset), 0);
        run(3, 1, 0);
        run(5000, 0, 0);               // single period after short enable
        chk("R7", int'(dith_offset), 0);
        for (int k = 0; k < 13; k++) run(700, 1, k[0]);
        run(5000, 0, 0);
        chk("R4", max_full, 4094);
        chk("R9", max_half, 2047);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule